// File: doc/BRIEF.md
# Loss-of-Signal Detector with Holdover Word Select

This block sits beside a clock-recovery loop. It samples the incoming serial data line on every rising edge of the bit clock and counts how many edges in a row have seen no change in the sampled level. Once that run reaches a set length, it raises a loss-of-signal flag. The first sampled change drops the flag again.

The block also owns the control word that goes to the oscillator. Normally the word comes straight from the loop filter. When the holdover request is high, a fixed centre-frequency code replaces it, so the oscillator stops following a dead input. The usual hookup feeds the flag back into the holdover request, which puts the loop into holdover on its own when the input goes quiet.

A global output enable forces every recovered clock and data lane low when it is deasserted. Reset is asynchronous and active low. The reset input is assumed to be released in step with the clock by logic upstream of the block.

Top module: `los_holdover_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, the flag is low and the oscillator word equals the loop word. The previous-sample reference is 0 after reset.
- R2: The data line is sampled at each rising edge. An edge is quiet when its sample equals the sample from the edge before. The flag is high right after the edge that completes RUN_LIMIT (default 256) consecutive quiet edges, and it stays high while the edges stay quiet.
- R3: After any edge whose sample differs from the previous one, the flag is low, whatever its state before.
- R4: The flag is never high after fewer than RUN_LIMIT consecutive quiet edges. After exactly 255 such edges (default) it is still low.
- R5: After a rising edge that sampled the holdover request high, the oscillator word is CENTER_WORD. Its default is mid-scale: only the top bit of the word is set.
- R6: After a rising edge that sampled the holdover request low, the oscillator word follows the loop word input combinationally.
- R7: While the output enable is low, every clock lane and data lane output is 0. While it is high, each output equals its input lane.
- R8: With the flag wired to the holdover request, a quiet line of RUN_LIMIT edges yields CENTER_WORD one edge after the flag rises. The loop word returns one edge after a transition clears the flag.
- R9: During holdover, changes on the loop word input have no effect on the oscillator word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rx_data_i | input | 1 | Incoming serial data line being monitored |
| hold_req_i | input | 1 | Holdover request; high selects the centre-frequency word |
| loop_word_i | input | CW_W | Control word from the loop filter |
| out_en_i | input | 1 | Output enable; low forces all lanes low |
| clk_lane_i | input | N_CLK | Clock lanes to be gated |
| data_lane_i | input | N_DAT | Data lanes to be gated |
| los_flag_o | output | 1 | Loss-of-signal flag |
| osc_word_o | output | CW_W | Control word to the oscillator |
| clk_lane_o | output | N_CLK | Gated clock lanes |
| data_lane_o | output | N_DAT | Gated data lanes |

## Verification
The bench aims at the run boundary. It holds the line quiet for exactly 255 edges and checks the flag is still low, then adds one more edge and checks it rises. A counter that was off by one, or that restarted on the wrong edge, would set the flag a cycle early or late. The bench then flips the line once while the flag is high: a design that cleared only after a fresh run, or that missed the comparison against the held sample, would leave the flag stuck high. Closing the loop from the flag to the holdover request, changing the loop word under holdover, and pulling reset while the flag is high each expose a mux that leaks the loop word or a flag that survives reset.

// File: rtl/los_pkg.sv
package los_pkg;

  // Selection state of the oscillator control word
  typedef enum logic {
    WSEL_LOOP = 1'b0,
    WSEL_HOLD = 1'b1
  } wsel_e;

  // Counter width able to hold the value lim
  function automatic int run_cnt_width(input int lim);
    return $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/los_xition_det.sv
// Samples the data line once per edge and flags a change against the held sample.
module los_xition_det (
  input  logic clk,
  input  logic rst_n,
  input  logic data_i,
  output logic xition_o
);

  logic smp_q;
  logic smp_d;

  always_comb begin
    smp_d    = data_i;
    xition_o = data_i ^ smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
    end
  end

endmodule

// File: rtl/los_run_ctr.sv
// Saturating run-length counter of quiet edges, plus the registered flag.
module los_run_ctr
  import los_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xition_i,
  output logic flag_o
);

  localparam int CNT_W = run_cnt_width(RUN_LIMIT);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(RUN_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             flag_q;
  logic             flag_d;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (xition_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != LIM_C) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
    flag_d = (cnt_d == LIM_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/los_word_sel.sv
// Registered holdover selection steering the oscillator control word.
module los_word_sel
  import los_pkg::*;
#(
  parameter int unsigned       CW_W        = 12,
  parameter logic [CW_W-1:0]   CENTER_WORD = {1'b1, {(CW_W-1){1'b0}}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_req_i,
  input  logic [CW_W-1:0] loop_word_i,
  output logic [CW_W-1:0] word_o
);

  wsel_e sel_q;
  wsel_e sel_d;

  always_comb begin
    sel_d  = hold_req_i ? WSEL_HOLD : WSEL_LOOP;
    word_o = (sel_q == WSEL_HOLD) ? CENTER_WORD : loop_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= WSEL_LOOP;
    end else begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/los_out_gate.sv
// Forces a bundle of lanes low when the enable is deasserted.
module los_out_gate #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] lane_i,
  output logic [WIDTH-1:0] lane_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign lane_o[i] = lane_i[i] & en_i;
  end

endmodule

// File: rtl/los_holdover_ctrl.sv
module los_holdover_ctrl
  import los_pkg::*;
#(
  parameter int unsigned     RUN_LIMIT   = 256,
  parameter int unsigned     CW_W        = 12,
  parameter logic [CW_W-1:0] CENTER_WORD = {1'b1, {(CW_W-1){1'b0}}},
  parameter int unsigned     N_CLK       = 2,
  parameter int unsigned     N_DAT       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_data_i,
  input  logic             hold_req_i,
  input  logic [CW_W-1:0]  loop_word_i,
  input  logic             out_en_i,
  input  logic [N_CLK-1:0] clk_lane_i,
  input  logic [N_DAT-1:0] data_lane_i,
  output logic             los_flag_o,
  output logic [CW_W-1:0]  osc_word_o,
  output logic [N_CLK-1:0] clk_lane_o,
  output logic [N_DAT-1:0] data_lane_o
);

  logic xition;

  los_xition_det u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_i   (rx_data_i),
    .xition_o (xition)
  );

  los_run_ctr #(
    .RUN_LIMIT (RUN_LIMIT)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .xition_i (xition),
    .flag_o   (los_flag_o)
  );

  los_word_sel #(
    .CW_W        (CW_W),
    .CENTER_WORD (CENTER_WORD)
  ) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_req_i  (hold_req_i),
    .loop_word_i (loop_word_i),
    .word_o      (osc_word_o)
  );

  los_out_gate #(
    .WIDTH (N_CLK)
  ) u_gate_clk (
    .en_i   (out_en_i),
    .lane_i (clk_lane_i),
    .lane_o (clk_lane_o)
  );

  los_out_gate #(
    .WIDTH (N_DAT)
  ) u_gate_dat (
    .en_i   (out_en_i),
    .lane_i (data_lane_i),
    .lane_o (data_lane_o)
  );

endmodule

// File: rtl/los_holdover_ctrl_chk.sv
module los_holdover_ctrl_chk
  import los_pkg::*;
#(
  parameter int unsigned     RUN_LIMIT   = 256,
  parameter int unsigned     CW_W        = 12,
  parameter logic [CW_W-1:0] CENTER_WORD = {1'b1, {(CW_W-1){1'b0}}},
  parameter int unsigned     N_CLK       = 2,
  parameter int unsigned     N_DAT       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_data_i,
  input logic             hold_req_i,
  input logic [CW_W-1:0]  loop_word_i,
  input logic             out_en_i,
  input logic [N_CLK-1:0] clk_lane_i,
  input logic [N_DAT-1:0] data_lane_i,
  input logic             los_flag_o,
  input logic [CW_W-1:0]  osc_word_o,
  input logic [N_CLK-1:0] clk_lane_o,
  input logic [N_DAT-1:0] data_lane_o
);

  localparam int CNT_W = run_cnt_width(RUN_LIMIT);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(RUN_LIMIT);

  // Independent quiet-run window kept by the checker
  logic             seen_q;
  logic             prev_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      prev_q <= rx_data_i;
      if (rx_data_i != prev_q)  run_q <= '0;
      else if (run_q != LIM_C)  run_q <= run_q + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!los_flag_o && osc_word_o == loop_word_i));

  p_flag_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == LIM_C) |-> los_flag_o);

  p_flag_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_i != prev_q) |=> !los_flag_o);

  p_no_early_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != LIM_C) |-> !los_flag_o);

  p_hold_centre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(hold_req_i)) |-> (osc_word_o == CENTER_WORD));

  p_loop_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(hold_req_i)) |-> (osc_word_o == loop_word_i));

  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |-> (clk_lane_o == '0 && data_lane_o == '0));

  p_gate_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_i |-> (clk_lane_o == clk_lane_i && data_lane_o == data_lane_i));

endmodule

bind los_holdover_ctrl los_holdover_ctrl_chk #(
  .RUN_LIMIT   (RUN_LIMIT),
  .CW_W        (CW_W),
  .CENTER_WORD (CENTER_WORD),
  .N_CLK       (N_CLK),
  .N_DAT       (N_DAT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_data_i   (rx_data_i),
  .hold_req_i  (hold_req_i),
  .loop_word_i (loop_word_i),
  .out_en_i    (out_en_i),
  .clk_lane_i  (clk_lane_i),
  .data_lane_i (data_lane_i),
  .los_flag_o  (los_flag_o),
  .osc_word_o  (osc_word_o),
  .clk_lane_o  (clk_lane_o),
  .data_lane_o (data_lane_o)
);

// File: tb/los_holdover_ctrl_tb_top.sv
`timescale 1ns/1ps
module los_holdover_ctrl_tb_top;

  localparam int unsigned     RUN_LIMIT = 256;
  localparam int unsigned     CW_W      = 12;
  localparam int unsigned     N_CLK     = 3;
  localparam int unsigned     N_DAT     = 2;
  localparam logic [CW_W-1:0] CENTER    = 12'h800;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rx_data;
  logic             hold_req;
  logic [CW_W-1:0]  loop_word;
  logic             out_en;
  logic [N_CLK-1:0] clk_lane_in;
  logic [N_DAT-1:0] data_lane_in;
  logic             los_flag;
  logic [CW_W-1:0]  osc_word;
  logic [N_CLK-1:0] clk_lane_out;
  logic [N_DAT-1:0] data_lane_out;

  always #2 clk = ~clk;

  los_holdover_ctrl #(
    .RUN_LIMIT (RUN_LIMIT),
    .CW_W      (CW_W),
    .N_CLK     (N_CLK),
    .N_DAT     (N_DAT)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data_i   (rx_data),
    .hold_req_i  (hold_req),
    .loop_word_i (loop_word),
    .out_en_i    (out_en),
    .clk_lane_i  (clk_lane_in),
    .data_lane_i (data_lane_in),
    .los_flag_o  (los_flag),
    .osc_word_o  (osc_word),
    .clk_lane_o  (clk_lane_out),
    .data_lane_o (data_lane_out)
  );

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  // Reference state derived from the requirements
  logic m_prev;
  int   m_run;
  logic m_sel;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_flag();
    return (m_run == RUN_LIMIT);
  endfunction

  function automatic logic [CW_W-1:0] exp_word(input logic [CW_W-1:0] lw);
    return m_sel ? CENTER : lw;
  endfunction

  task automatic check_all();
    logic             ef;
    logic [N_CLK-1:0] ec;
    logic [N_DAT-1:0] ed;
    ef = exp_flag();
    ec = out_en ? clk_lane_in  : '0;
    ed = out_en ? data_lane_in : '0;
    chk(los_flag == ef, ef ? "R2" : "R4", "flag", los_flag, ef);
    chk(osc_word == exp_word(loop_word), m_sel ? "R5" : "R6", "osc_word",
        osc_word, exp_word(loop_word));
    chk(clk_lane_out == ec && data_lane_out == ed, "R7", "lanes",
        {clk_lane_out, data_lane_out}, {ec, ed});
  endtask

  task automatic step(input logic d, input logic h, input logic [CW_W-1:0] lw,
                      input logic oe);
    @(negedge clk);
    rx_data      = d;
    hold_req     = h;
    loop_word    = lw;
    out_en       = oe;
    clk_lane_in  = N_CLK'($urandom);
    data_lane_in = N_DAT'($urandom);
    @(posedge clk);
    if (d != m_prev)            m_run = 0;
    else if (m_run < RUN_LIMIT) m_run = m_run + 1;
    m_prev = d;
    m_sel  = h;
    #1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    loop_word = CW_W'($urandom);
    repeat (3) @(posedge clk);
    #1;
    chk(los_flag == 1'b0, "R1", "flag in reset", los_flag, 0);
    chk(osc_word == loop_word, "R1", "word in reset", osc_word, loop_word);
    @(negedge clk);
    rst_n  = 1'b1;
    m_prev = 1'b0;
    m_run  = 0;
    m_sel  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=200000 cycles expected=fewer");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic d;
    void'($urandom(32'd20240611));
    rst_n        = 1'b0;
    rx_data      = 1'b1;
    hold_req     = 1'b0;
    loop_word    = '0;
    out_en       = 1'b1;
    clk_lane_in  = '0;
    data_lane_in = '0;
    do_reset();

    // Random busy traffic, random holdover and enable
    for (int i = 0; i < 300; i++) begin
      step(1'($urandom), 1'($urandom), CW_W'($urandom), 1'($urandom));
    end

    // R4 / R2 boundary: exactly 255 quiet edges, then the 256th
    d = ~m_prev;
    step(d, 1'b0, CW_W'($urandom), 1'b1);
    for (int i = 0; i < 255; i++) step(d, 1'b0, CW_W'($urandom), 1'b1);
    chk(los_flag == 1'b0, "R4", "flag after 255 quiet edges", los_flag, 0);
    step(d, 1'b0, CW_W'($urandom), 1'b1);
    chk(los_flag == 1'b1, "R2", "flag after 256 quiet edges", los_flag, 1);
    for (int i = 0; i < 20; i++) step(d, 1'b0, CW_W'($urandom), 1'b1);
    chk(los_flag == 1'b1, "R2", "flag held while quiet", los_flag, 1);
    step(~d, 1'b0, CW_W'($urandom), 1'b1);
    chk(los_flag == 1'b0, "R3", "flag after first change", los_flag, 0);

    // R9: loop word wiggles under holdover
    step(~d, 1'b1, CW_W'($urandom), 1'b1);
    for (int i = 0; i < 40; i++) begin
      step(1'($urandom), 1'b1, CW_W'($urandom), 1'b1);
      chk(osc_word == CENTER, "R9", "word under holdover", osc_word, CENTER);
    end

    // R8: flag drives holdover request
    d = m_prev;
    for (int i = 0; i < RUN_LIMIT + 4; i++) step(d, los_flag, CW_W'($urandom), 1'b1);
    chk(osc_word == CENTER, "R8", "auto holdover word", osc_word, CENTER);
    step(~d, los_flag, CW_W'($urandom), 1'b1);
    step(~d, los_flag, CW_W'($urandom), 1'b1);
    chk(osc_word == loop_word, "R8", "auto release word", osc_word, loop_word);

    // R1: reset while flag is high
    d = m_prev;
    for (int i = 0; i < RUN_LIMIT + 2; i++) step(d, 1'b1, CW_W'($urandom), 1'b1);
    do_reset();
    step(1'b0, 1'b0, CW_W'($urandom), 1'b1);
    chk(los_flag == 1'b0, "R1", "flag after reset", los_flag, 0);

    // Sparse traffic: long runs with rare changes, auto holdover
    d = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 299) == 0) d = ~d;
      step(d, los_flag, CW_W'($urandom), ($urandom_range(0, 9) != 0));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule